// File: doc/BRIEF.md
# Cipher Context Register Bank with End-of-Message Gating

This block is the host-side control and context store of a block-cipher engine. It holds twelve 64-bit context registers. The host reads and writes them over a flat register bus. The same bus carries an end-of-message strobe, a status word, an interrupt-enable word and a mode selector.

On the data side the block watches the occupancy of the engine's input FIFO and drives the pop that hands a block to the cipher core. It never lets the final queued block go to the core until the host has written the end-of-message strobe. After that strobe it drains the FIFO, waits for the core to go idle, and raises a sticky done flag.

A context write made while a message is in flight is refused and raises a sticky context-error flag. The mode selector sets the highest context register that the active cipher mode uses. A saved or restored context is a contiguous run of registers ending at that register, so writes to registers above it are dropped.

Top module: `cctx_bank`

## Requirements
- R1: Addresses 0 to 11 select context registers 1 to 12. Each is 64 bits wide, and each reads back the last accepted write.
- R2: Address 12 is the end-of-message strobe. Any write there arms the end of message whatever the data value, and a read of address 12 always returns zero.
- R3: `blk_pop_o` is high only while `core_rdy_i` is high and either the FIFO count is at least 2, or the count is exactly 1 and an end-of-message is armed. The last queued block is therefore held until the strobe.
- R4: Once end-of-message is armed, the done flag (status bit 1) is set on the clock edge after the cycle in which the FIFO count is 0 and `core_busy_i` is low. With an empty FIFO and an idle core, this is the second edge after the strobe write.
- R5: A write to addresses 0 to 11 while busy sets the context-error flag (status bit 0) and leaves every context register unchanged.
- R6: `init_i`, `soft_rst_i` and `rst_n` each clear all context registers, both status flags, the busy state and any armed end-of-message.
- R7: The mode field (address 15, bits 1:0; reset value 3) gives the highest usable register: code 0 is register 4, 1 is register 7 (counter mode), 2 is register 9 and 3 is register 12. Writes to context registers above that one are ignored.
- R8: The busy flag (status bit 2) sets on the first block popped and clears on the edge that sets done.
- R9: The status flags at address 13 are cleared by writing 1 to bits 0 and 1. The enable word at address 14 (bit 0 for error, bit 1 for done) resets to 0. `irq_o` is the OR of the enabled flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| init_i | input | 1 | Synchronous initialization command |
| soft_rst_i | input | 1 | Synchronous soft reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register address |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Register read data, combinational on the address |
| fifo_count_i | input | 6 | Blocks currently queued in the input FIFO |
| core_rdy_i | input | 1 | Cipher core can accept a block |
| core_busy_i | input | 1 | Cipher core is working on a block |
| blk_pop_o | output | 1 | Hand one FIFO block to the core this cycle |
| irq_o | output | 1 | Interrupt, OR of enabled sticky flags |

## Verification
The hardest state to reach is a refused context write. It needs the block to be busy, with unprocessed data still queued and no end-of-message armed. The bench reaches it with a small FIFO and core model. It queues three blocks and lets the model drain until only the held last block remains, which leaves the unit busy indefinitely. In that window it issues the illegal write, checks the flag and the unchanged contents, and only then writes the strobe and checks that the held block drains to done.

// File: rtl/cctx_pkg.sv
package cctx_pkg;
  localparam int unsigned N_CTX  = 12;
  localparam int unsigned DW     = 64;
  localparam int unsigned AW     = 5;
  localparam int unsigned CW     = 6;
  localparam int unsigned IDX_W  = $clog2(N_CTX);

  localparam logic [AW-1:0] A_EOM  = AW'(N_CTX);
  localparam logic [AW-1:0] A_STS  = AW'(N_CTX + 1);
  localparam logic [AW-1:0] A_IEN  = AW'(N_CTX + 2);
  localparam logic [AW-1:0] A_MODE = AW'(N_CTX + 3);

  typedef enum logic [1:0] {
    MODE_SHORT = 2'd0,
    MODE_CTR   = 2'd1,
    MODE_MID   = 2'd2,
    MODE_FULL  = 2'd3
  } mode_e;

  // Highest register number (1-based) that a mode keeps as context
  function automatic logic [IDX_W:0] mode_top(input mode_e m);
    case (m)
      MODE_SHORT: mode_top = (IDX_W+1)'(4);
      MODE_CTR:   mode_top = (IDX_W+1)'(7);
      MODE_MID:   mode_top = (IDX_W+1)'(9);
      default:    mode_top = (IDX_W+1)'(N_CTX);
    endcase
  endfunction
endpackage

// File: rtl/cctx_regfile.sv
module cctx_regfile
  import cctx_pkg::*;
#(
  parameter int unsigned NREG = N_CTX,
  parameter int unsigned W    = DW,
  localparam int unsigned IW  = $clog2(NREG)
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    wr_en,
  input  logic [IW-1:0]           wr_idx,
  input  logic [W-1:0]            wr_data,
  output logic [NREG-1:0][W-1:0]  regs
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic         ld;
    logic [W-1:0] d;
    always_comb begin
      ld = clr || (wr_en && (wr_idx == IW'(g)));
      d  = clr ? '0 : wr_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  regs[g] <= '0;
      else if (ld) regs[g] <= d;
    end
  end
endmodule

// File: rtl/cctx_flow.sv
module cctx_flow
  import cctx_pkg::*;
#(
  parameter int unsigned FW = CW
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          eom_wr,
  input  logic [FW-1:0] fifo_count,
  input  logic          core_rdy,
  input  logic          core_busy,
  output logic          pop,
  output logic          busy,
  output logic          eom_pend,
  output logic          finish
);
  logic busy_d, eom_d;

  always_comb begin
    pop    = core_rdy && ((fifo_count > FW'(1)) ||
                          ((fifo_count == FW'(1)) && eom_pend));
    finish = eom_pend && (fifo_count == '0) && !core_busy && !pop;
    busy_d = busy;
    eom_d  = eom_pend;
    if (pop)    busy_d = 1'b1;
    if (eom_wr) eom_d  = 1'b1;
    if (finish) begin
      busy_d = 1'b0;
      eom_d  = 1'b0;
    end
    if (clr) begin
      busy_d = 1'b0;
      eom_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      eom_pend <= 1'b0;
    end else begin
      busy     <= busy_d;
      eom_pend <= eom_d;
    end
  end
endmodule

// File: rtl/cctx_bank.sv
module cctx_bank
  import cctx_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_i,
  input  logic          soft_rst_i,
  input  logic          reg_wr_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic [CW-1:0] fifo_count_i,
  input  logic          core_rdy_i,
  input  logic          core_busy_i,
  output logic          blk_pop_o,
  output logic          irq_o
);
  logic                     clr;
  logic                     is_ctx, ctx_ok, ctx_bad, eom_wr;
  logic                     busy_q, eom_pend_q, finish;
  logic [N_CTX-1:0][DW-1:0] ctx_q;
  logic                     err_q, done_q, err_d, done_d;
  logic [1:0]               ien_q, ien_d;
  mode_e                    mode_q, mode_d;

  always_comb begin
    clr     = init_i || soft_rst_i;
    is_ctx  = reg_wr_i && (reg_addr_i < AW'(N_CTX));
    ctx_bad = is_ctx && busy_q;
    ctx_ok  = is_ctx && !busy_q &&
              ((IDX_W+1)'(reg_addr_i) < mode_top(mode_q));
    eom_wr  = reg_wr_i && (reg_addr_i == A_EOM) && !clr;
  end

  cctx_regfile #(.NREG(N_CTX), .W(DW)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .wr_en   (ctx_ok),
    .wr_idx  (reg_addr_i[IDX_W-1:0]),
    .wr_data (reg_wdata_i),
    .regs    (ctx_q)
  );

  cctx_flow #(.FW(CW)) u_flow (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .eom_wr     (eom_wr),
    .fifo_count (fifo_count_i),
    .core_rdy   (core_rdy_i),
    .core_busy  (core_busy_i),
    .pop        (blk_pop_o),
    .busy       (busy_q),
    .eom_pend   (eom_pend_q),
    .finish     (finish)
  );

  // Next-state for status, enables and mode
  always_comb begin
    err_d  = err_q;
    done_d = done_q;
    ien_d  = ien_q;
    mode_d = mode_q;
    if (reg_wr_i && reg_addr_i == A_STS) begin
      if (reg_wdata_i[0]) err_d  = 1'b0;
      if (reg_wdata_i[1]) done_d = 1'b0;
    end
    if (reg_wr_i && reg_addr_i == A_IEN)  ien_d  = reg_wdata_i[1:0];
    if (reg_wr_i && reg_addr_i == A_MODE) mode_d = mode_e'(reg_wdata_i[1:0]);
    if (ctx_bad) err_d  = 1'b1;
    if (finish)  done_d = 1'b1;
    if (clr) begin
      err_d  = 1'b0;
      done_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= 1'b0;
      done_q <= 1'b0;
      ien_q  <= 2'b00;
      mode_q <= MODE_FULL;
    end else begin
      err_q  <= err_d;
      done_q <= done_d;
      ien_q  <= ien_d;
      mode_q <= mode_d;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i < AW'(N_CTX)) reg_rdata_o = ctx_q[reg_addr_i[IDX_W-1:0]];
    else if (reg_addr_i == A_STS)  reg_rdata_o = DW'({busy_q, done_q, err_q});
    else if (reg_addr_i == A_IEN)  reg_rdata_o = DW'(ien_q);
    else if (reg_addr_i == A_MODE) reg_rdata_o = DW'(mode_q);
    irq_o = (err_q && ien_q[0]) || (done_q && ien_q[1]);
  end
endmodule

// File: rtl/cctx_bank_chk.sv
module cctx_bank_chk
  import cctx_pkg::*;
(
  input logic                     clk,
  input logic                     rst_n,
  input logic                     init_i,
  input logic                     soft_rst_i,
  input logic                     reg_wr_i,
  input logic [AW-1:0]            reg_addr_i,
  input logic [DW-1:0]            reg_rdata_o,
  input logic [CW-1:0]            fifo_count_i,
  input logic                     core_rdy_i,
  input logic                     core_busy_i,
  input logic                     blk_pop_o,
  input logic                     busy_q,
  input logic                     eom_pend_q,
  input logic                     done_q,
  input logic [N_CTX-1:0][DW-1:0] ctx_q
);
  a_r2_eom_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i == A_EOM) |-> (reg_rdata_o == '0));

  a_r3_last_block_held: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_pop_o && fifo_count_i == CW'(1)) |-> eom_pend_q);

  a_r3_pop_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    blk_pop_o |-> (core_rdy_i && fifo_count_i != '0));

  a_r4_done_when_drained: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_q ##1 done_q) |-> $past(fifo_count_i == '0 && !core_busy_i));

  a_r5_busy_write_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i < AW'(N_CTX) && busy_q && !init_i && !soft_rst_i)
      |=> $stable(ctx_q));

  a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (init_i || soft_rst_i) |=> (ctx_q == '0 && !busy_q && !done_q));

  a_r8_busy_on_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_pop_o && !init_i && !soft_rst_i) |=> busy_q);
endmodule

bind cctx_bank cctx_bank_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .init_i       (init_i),
  .soft_rst_i   (soft_rst_i),
  .reg_wr_i     (reg_wr_i),
  .reg_addr_i   (reg_addr_i),
  .reg_rdata_o  (reg_rdata_o),
  .fifo_count_i (fifo_count_i),
  .core_rdy_i   (core_rdy_i),
  .core_busy_i  (core_busy_i),
  .blk_pop_o    (blk_pop_o),
  .busy_q       (busy_q),
  .eom_pend_q   (eom_pend_q),
  .done_q       (done_q),
  .ctx_q        (ctx_q)
);

// File: tb/cctx_bank_tb_top.sv
`timescale 1ns/1ps
module cctx_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, init_i, soft_rst_i, reg_wr_i;
  logic [4:0]  reg_addr_i;
  logic [63:0] reg_wdata_i, reg_rdata_o;
  logic [5:0]  fifo_count_i;
  logic        core_rdy_i, core_busy_i, blk_pop_o, irq_o;

  int checks = 0;
  int errors = 0;
  int pops   = 0;
  int core_left = 0;
  logic push_req = 1'b0;

  always #2 clk = ~clk;

  cctx_bank dut_i (
    .clk(clk), .rst_n(rst_n), .init_i(init_i), .soft_rst_i(soft_rst_i),
    .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .fifo_count_i(fifo_count_i),
    .core_rdy_i(core_rdy_i), .core_busy_i(core_busy_i),
    .blk_pop_o(blk_pop_o), .irq_o(irq_o)
  );

  // FIFO and core model: each popped block keeps the core busy 3 cycles
  assign core_busy_i = (core_left != 0);
  assign core_rdy_i  = !core_busy_i;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_count_i <= '0;
      core_left    <= 0;
    end else begin
      fifo_count_i <= fifo_count_i + (push_req ? 6'd1 : 6'd0)
                                   - (blk_pop_o ? 6'd1 : 6'd0);
      if (blk_pop_o) begin
        core_left <= 3;
        pops      <= pops + 1;
      end else if (core_left != 0) core_left <= core_left - 1;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 1'b0; reg_addr_i = 5'd31;
  endtask

  task automatic rd(input logic [4:0] a, output logic [63:0] d);
    @(negedge clk);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic push_blocks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); push_req = 1'b1;
    end
    @(negedge clk); push_req = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [63:0] v;
    rd(5'd0, v);  chk("R6 reset ctx1", v, 64'd0);
    rd(5'd13, v); chk("R6 reset status", v, 64'd0);
    chk("R9 reset irq", {63'd0, irq_o}, 64'd0);
    rd(5'd15, v); chk("R7 reset mode", v, 64'd3);
  endtask

  task automatic t_rw;
    logic [63:0] v;
    wr(5'd0,  64'h0123_4567_89AB_CDEF);
    wr(5'd11, 64'hFEDC_BA98_7654_3210);
    rd(5'd0, v);  chk("R1 ctx1 readback", v, 64'h0123_4567_89AB_CDEF);
    rd(5'd11, v); chk("R1 ctx12 readback", v, 64'hFEDC_BA98_7654_3210);
  endtask

  task automatic t_eom_idle;
    logic [63:0] v;
    // write strobe with nonzero data; done lands on second edge after it
    @(negedge clk);
    reg_wr_i = 1'b1; reg_addr_i = 5'd12; reg_wdata_i = 64'hDEAD_BEEF;
    @(negedge clk);
    reg_wr_i = 1'b0; reg_addr_i = 5'd13;
    #1 chk("R4 done not yet", reg_rdata_o & 64'h2, 64'd0);
    @(negedge clk);
    #1 chk("R4 done after idle eom", reg_rdata_o & 64'h2, 64'h2);
    rd(5'd12, v); chk("R2 eom reads zero", v, 64'd0);
    wr(5'd13, 64'h2);
    rd(5'd13, v); chk("R9 w1c done", v, 64'd0);
  endtask

  task automatic t_mode;
    logic [63:0] v;
    wr(5'd15, 64'd1);
    wr(5'd7, 64'h1111);
    wr(5'd6, 64'h2222);
    rd(5'd7, v); chk("R7 ctr reg8 ignored", v, 64'd0);
    rd(5'd6, v); chk("R7 ctr reg7 written", v, 64'h2222);
    wr(5'd15, 64'd3);
  endtask

  task automatic t_hold_and_err;
    logic [63:0] v;
    wr(5'd14, 64'h3);
    push_blocks(3);
    wait_cyc(20);
    chk("R3 last block held count", {58'd0, fifo_count_i}, 64'd1);
    chk("R3 pops before eom", 64'(pops), 64'd2);
    rd(5'd13, v); chk("R8 busy while held", v, 64'h4);
    wr(5'd0, 64'hAAAA);
    rd(5'd0, v);  chk("R5 ctx unchanged", v, 64'h0123_4567_89AB_CDEF);
    rd(5'd13, v); chk("R5 err flag set", v & 64'h1, 64'h1);
    chk("R9 irq on err", {63'd0, irq_o}, 64'd1);
    wr(5'd13, 64'h1);
    chk("R9 irq cleared", {63'd0, irq_o}, 64'd0);
    wr(5'd12, 64'd0);
    wait_cyc(12);
    chk("R4 fifo drained", {58'd0, fifo_count_i}, 64'd0);
    rd(5'd13, v); chk("R4 R8 done set busy clear", v, 64'h2);
    chk("R9 irq on done", {63'd0, irq_o}, 64'd1);
  endtask

  task automatic t_clear;
    logic [63:0] v;
    @(negedge clk); soft_rst_i = 1'b1;
    @(negedge clk); soft_rst_i = 1'b0;
    rd(5'd0, v);  chk("R6 soft reset ctx1", v, 64'd0);
    rd(5'd11, v); chk("R6 soft reset ctx12", v, 64'd0);
    rd(5'd13, v); chk("R6 soft reset status", v, 64'd0);
    wr(5'd3, 64'h55);
    @(negedge clk); init_i = 1'b1;
    @(negedge clk); init_i = 1'b0;
    rd(5'd3, v); chk("R6 init clears ctx4", v, 64'd0);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; init_i = 1'b0; soft_rst_i = 1'b0; reg_wr_i = 1'b0;
    reg_addr_i = 5'd31; reg_wdata_i = '0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    t_reset();
    t_rw();
    t_eom_idle();
    t_mode();
    t_hold_and_err();
    t_clear();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule